// File: doc/BRIEF.md
# Typed Memory-Mapped Register with Access Checking

This block is a single control/status register placed between a bus-slave controller and the functional logic it serves. Each cycle it compares the bus address with the address it was built with and flags a hit. An access type, fixed per instance, decides which bus operations it accepts:

- read-only: the register follows the functional block.
- write-only and read-write: the register is loaded by the bus.
- clear-on-read: the register gathers event bits until the bus reads them.
- constant: the register always returns its build-time value.

Legality goes back to the bus controller on two combinational strobes, a write acknowledge and a read data-valid. The stored value is always driven toward the functional block, and it is driven on the read-data port only while a read is legal.

Each instance sets its address, initial value, access type and reset polarity as parameters. Reset takes effect asynchronously. Its release is synchronised over two clock edges. While reset is in force, or during the release edges, no access is legal.

Top module: `typed_csr`

## Requirements
- R1: `hit` is high exactly when `bus_addr` equals the parameter `REG_ADDR`, and neither `wr_ack` nor `rd_valid` is ever high without `hit`.
- R2: For types write-only (code 1) and read-write (code 2), a write with `hit` and `wr_en` high sets `wr_ack` in that cycle, and `blk_out` shows `wr_data` after the next rising edge. Back-to-back writes are each acknowledged, and `blk_in` never overrides the written value.
- R3: For types read-only (code 0), clear-on-read (code 3) and constant (code 4), `wr_ack` stays low on any write, and the write leaves the value untouched.
- R4: A read with `hit` and `rd_en` high sets `rd_valid` in that cycle for types 0, 2, 3 and 4, with `rd_data` equal to the stored value. For type 1 it keeps `rd_valid` low.
- R5: A read or write whose address does not match leaves `rd_valid` and `wr_ack` low.
- R6: `rd_data` is all zeros whenever `rd_valid` is low.
- R7: A read-only register loads `blk_in` on every rising edge outside reset.
- R8: A clear-on-read register ORs `blk_in` into its value on every edge and keeps those bits after `blk_in` drops. A legal read clears it at the next edge, except for the bits present on `blk_in` in that same cycle, which remain.
- R9: A constant register always shows `INIT_VAL` on `blk_out` and ignores both `blk_in` and bus writes.
- R10: With `RST_LOW`=1 a low `rst_in` resets the block, and with `RST_LOW`=0 a high one does. Asserting reset forces the value to `INIT_VAL` at once, without a clock edge. Both strobes stay low until two rising edges after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_in | input | 1 | Reset, polarity set by RST_LOW |
| bus_addr | input | ADDR_W | Bus address of the current request |
| wr_en | input | 1 | Write request strobe |
| rd_en | input | 1 | Read request strobe |
| wr_data | input | DATA_W | Write data from the bus |
| blk_in | input | DATA_W | Data or event bits from the functional block |
| hit | output | 1 | Address matches this register |
| wr_ack | output | 1 | Write is legal and taken this cycle |
| rd_valid | output | 1 | Read is legal and rd_data is valid |
| rd_data | output | DATA_W | Stored value during a legal read, else zero |
| blk_out | output | DATA_W | Stored value toward the functional block |

## Verification
The bench aims at these corner cases, and each has a typical failure:

- **Block input against a bus write.** Two back-to-back writes go to a read-write register while `blk_in` is held at all ones. A design that let the block input through would show the wrong value on `blk_out`.
- **Event arriving during the clearing read.** An event bit arrives in the same cycle as a clear-on-read access. A design that cleared first and merged later, or dropped the new bits, would lose that event.
- **Reads that must fail.** One read targets a mismatched address and another targets the write-only register. A faulty design would raise `rd_valid` or let stale data onto `rd_data`.
- **Reset.** Reset is asserted in mid-run on instances of both polarities. An instance that waited for a clock edge to reset, or reset on the wrong polarity, would keep its old value.

// File: rtl/csr_pkg.sv
package csr_pkg;

  // Access type codes; the numeric values are part of the interface.
  typedef enum logic [2:0] {
    ACC_RO    = 3'd0,
    ACC_WO    = 3'd1,
    ACC_RW    = 3'd2,
    ACC_COR   = 3'd3,
    ACC_CONST = 3'd4
  } csr_acc_e;

  function automatic bit acc_writable(csr_acc_e a);
    return (a == ACC_WO) || (a == ACC_RW);
  endfunction

  function automatic bit acc_readable(csr_acc_e a);
    return a != ACC_WO;
  endfunction

endpackage

// File: rtl/csr_rst_sync.sv
module csr_rst_sync #(
  parameter bit ACT_LOW = 1'b1
) (
  input  logic clk,
  input  logic rst_in,
  output logic rst_ok
);
  logic       rst_act;
  logic [1:0] sync_q;

  assign rst_act = ACT_LOW ? ~rst_in : rst_in;

  // Assert at once, release after two edges.
  always_ff @(posedge clk or posedge rst_act) begin
    if (rst_act) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_ok = sync_q[1];
endmodule

// File: rtl/csr_addr_match.sv
module csr_addr_match #(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = '0
) (
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              hit
);
  assign hit = (bus_addr == REG_ADDR);
endmodule

// File: rtl/csr_access_gate.sv
module csr_access_gate
  import csr_pkg::*;
#(
  parameter csr_acc_e ACC = ACC_RW
) (
  input  logic rst_ok,
  input  logic hit,
  input  logic wr_en,
  input  logic rd_en,
  output logic wr_ok,
  output logic rd_ok
);
  localparam bit WR_LEGAL = acc_writable(ACC);
  localparam bit RD_LEGAL = acc_readable(ACC);

  assign wr_ok = rst_ok & hit & wr_en & WR_LEGAL;
  assign rd_ok = rst_ok & hit & rd_en & RD_LEGAL;
endmodule

// File: rtl/csr_next.sv
module csr_next
  import csr_pkg::*;
#(
  parameter int                DATA_W   = 8,
  parameter csr_acc_e          ACC      = ACC_RW,
  parameter logic [DATA_W-1:0] INIT_VAL = '0
) (
  input  logic [DATA_W-1:0] cur,
  input  logic              wr_ok,
  input  logic              rd_ok,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] blk_in,
  output logic              val_en,
  output logic [DATA_W-1:0] val_d
);
  always_comb begin
    val_en = 1'b0;
    val_d  = cur;
    case (ACC)
      ACC_RW, ACC_WO: begin
        val_en = wr_ok;
        val_d  = wr_data;
      end
      ACC_RO: begin
        val_en = 1'b1;
        val_d  = blk_in;
      end
      ACC_COR: begin
        // Events arriving with the clearing read survive it.
        val_en = 1'b1;
        val_d  = (rd_ok ? '0 : cur) | blk_in;
      end
      default: begin
        val_en = 1'b0;
        val_d  = INIT_VAL;
      end
    endcase
  end
endmodule

// File: rtl/typed_csr.sv
module typed_csr
  import csr_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter int                DATA_W   = 8,
  parameter csr_acc_e          ACC      = ACC_RW,
  parameter logic [ADDR_W-1:0] REG_ADDR = ADDR_W'(14),
  parameter logic [DATA_W-1:0] INIT_VAL = '0,
  parameter bit                RST_LOW  = 1'b1
) (
  input  logic              clk,
  input  logic              rst_in,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] blk_in,
  output logic              hit,
  output logic              wr_ack,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] blk_out
);
  logic              rst_ok;
  logic              val_en;
  logic [DATA_W-1:0] val_d;
  logic [DATA_W-1:0] val_q;

  csr_rst_sync #(.ACT_LOW(RST_LOW)) u_rst (
    .clk    (clk),
    .rst_in (rst_in),
    .rst_ok (rst_ok)
  );

  csr_addr_match #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_match (
    .bus_addr (bus_addr),
    .hit      (hit)
  );

  csr_access_gate #(.ACC(ACC)) u_gate (
    .rst_ok (rst_ok),
    .hit    (hit),
    .wr_en  (wr_en),
    .rd_en  (rd_en),
    .wr_ok  (wr_ack),
    .rd_ok  (rd_valid)
  );

  csr_next #(.DATA_W(DATA_W), .ACC(ACC), .INIT_VAL(INIT_VAL)) u_next (
    .cur     (val_q),
    .wr_ok   (wr_ack),
    .rd_ok   (rd_valid),
    .wr_data (wr_data),
    .blk_in  (blk_in),
    .val_en  (val_en),
    .val_d   (val_d)
  );

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok)     val_q <= INIT_VAL;
    else if (val_en) val_q <= val_d;
  end

  assign rd_data = rd_valid ? val_q : '0;
  assign blk_out = val_q;
endmodule

// File: rtl/csr_chk.sv
module csr_chk
  import csr_pkg::*;
#(
  parameter int                DATA_W   = 8,
  parameter csr_acc_e          ACC      = ACC_RW,
  parameter logic [DATA_W-1:0] INIT_VAL = '0
) (
  input logic              clk,
  input logic              rst_ok,
  input logic              hit,
  input logic              wr_en,
  input logic              wr_ack,
  input logic              rd_valid,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] blk_in,
  input logic [DATA_W-1:0] rd_data,
  input logic [DATA_W-1:0] blk_out
);
  AST_ACK_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_ok)
    (wr_ack || rd_valid) |-> hit);  // R1
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_ok)
    wr_ack |=> (blk_out == $past(wr_data)));  // R2
  AST_WRITE_REFUSED: assert property (@(posedge clk) disable iff (!rst_ok)
    (wr_en && hit && !acc_writable(ACC)) |-> !wr_ack);  // R3
  AST_WO_NO_READ: assert property (@(posedge clk) disable iff (!rst_ok)
    (ACC == ACC_WO) |-> !rd_valid);  // R4
  AST_IDLE_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_ok)
    !rd_valid |-> (rd_data == '0));  // R6
  AST_RO_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_ok)
    (ACC == ACC_RO) |=> (blk_out == $past(blk_in)));  // R7
  AST_COR_STICKY: assert property (@(posedge clk) disable iff (!rst_ok)
    (ACC == ACC_COR && !rd_valid) |=> ((blk_out & $past(blk_out)) == $past(blk_out)));  // R8
  AST_CONST_FIXED: assert property (@(posedge clk) disable iff (!rst_ok)
    (ACC == ACC_CONST) |-> (blk_out == INIT_VAL));  // R9
endmodule

bind typed_csr csr_chk #(
  .DATA_W   (DATA_W),
  .ACC      (ACC),
  .INIT_VAL (INIT_VAL)
) u_chk (
  .clk      (clk),
  .rst_ok   (rst_ok),
  .hit      (hit),
  .wr_en    (wr_en),
  .wr_ack   (wr_ack),
  .rd_valid (rd_valid),
  .wr_data  (wr_data),
  .blk_in   (blk_in),
  .rd_data  (rd_data),
  .blk_out  (blk_out)
);

// File: tb/typed_csr_tb.sv
module typed_csr_tb;
  import csr_pkg::*;

  localparam logic [7:0] ADDR  = 8'h0E;
  localparam logic [7:0] I_RW  = 8'hA5;
  localparam logic [7:0] I_WO  = 8'h3C;
  localparam logic [7:0] I_RO  = 8'h11;
  localparam logic [7:0] I_COR = 8'h00;
  localparam logic [7:0] I_CST = 8'h5A;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wr_data = '0, blk_in = '0;

  logic       hit_rw, hit_wo, hit_ro, hit_cor, hit_cst;
  logic       ack_rw, ack_wo, ack_ro, ack_cor, ack_cst;
  logic       vld_rw, vld_wo, vld_ro, vld_cor, vld_cst;
  logic [7:0] rdd_rw, rdd_wo, rdd_ro, rdd_cor, rdd_cst;
  logic [7:0] out_rw, out_wo, out_ro, out_cor, out_cst;

  logic [7:0] e_rw, e_wo, e_ro, e_cor, e_cst;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  typed_csr #(.ACC(ACC_RW), .REG_ADDR(ADDR), .INIT_VAL(I_RW)) u_dut (
    .clk(clk), .rst_in(rst_n), .bus_addr(bus_addr), .wr_en(wr_en), .rd_en(rd_en),
    .wr_data(wr_data), .blk_in(blk_in), .hit(hit_rw), .wr_ack(ack_rw),
    .rd_valid(vld_rw), .rd_data(rdd_rw), .blk_out(out_rw));
  typed_csr #(.ACC(ACC_WO), .REG_ADDR(ADDR), .INIT_VAL(I_WO)) u_dut_wo (
    .clk(clk), .rst_in(rst_n), .bus_addr(bus_addr), .wr_en(wr_en), .rd_en(rd_en),
    .wr_data(wr_data), .blk_in(blk_in), .hit(hit_wo), .wr_ack(ack_wo),
    .rd_valid(vld_wo), .rd_data(rdd_wo), .blk_out(out_wo));
  typed_csr #(.ACC(ACC_RO), .REG_ADDR(ADDR), .INIT_VAL(I_RO)) u_dut_ro (
    .clk(clk), .rst_in(rst_n), .bus_addr(bus_addr), .wr_en(wr_en), .rd_en(rd_en),
    .wr_data(wr_data), .blk_in(blk_in), .hit(hit_ro), .wr_ack(ack_ro),
    .rd_valid(vld_ro), .rd_data(rdd_ro), .blk_out(out_ro));
  typed_csr #(.ACC(ACC_COR), .REG_ADDR(ADDR), .INIT_VAL(I_COR), .RST_LOW(1'b0)) u_dut_cor (
    .clk(clk), .rst_in(~rst_n), .bus_addr(bus_addr), .wr_en(wr_en), .rd_en(rd_en),
    .wr_data(wr_data), .blk_in(blk_in), .hit(hit_cor), .wr_ack(ack_cor),
    .rd_valid(vld_cor), .rd_data(rdd_cor), .blk_out(out_cor));
  typed_csr #(.ACC(ACC_CONST), .REG_ADDR(ADDR), .INIT_VAL(I_CST)) u_dut_cst (
    .clk(clk), .rst_in(rst_n), .bus_addr(bus_addr), .wr_en(wr_en), .rd_en(rd_en),
    .wr_data(wr_data), .blk_in(blk_in), .hit(hit_cst), .wr_ack(ack_cst),
    .rd_valid(vld_cst), .rd_data(rdd_cst), .blk_out(out_cst));

  task automatic chk(bit ok, string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Expected next value from the requirements (type codes 0..4).
  function automatic logic [7:0] nxt(int acc, logic [7:0] cur, bit ch, bit wr, bit rd,
                                     logic [7:0] wd, logic [7:0] bi);
    case (acc)
      0:       return bi;                                   // R7
      1, 2:    return (ch && wr) ? wd : cur;                // R2, R3
      3:       return ((ch && rd) ? 8'h00 : cur) | bi;      // R8
      default: return cur;                                  // R9
    endcase
  endfunction

  function automatic string out_tag(int acc);
    case (acc)
      0: return "R7";
      1, 2: return "R2";
      3: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic chk_inst(int acc, logic [7:0] ev, bit ch, logic hv, logic ack,
                          logic vld, logic [7:0] rdd, logic [7:0] ov);
    bit wrl = (acc == 1 || acc == 2);
    bit eack = ch && wr_en && wrl;
    bit evld = ch && rd_en && (acc != 1);
    chk(hv == ch, "R1", {7'd0, hv}, {7'd0, ch});
    chk(ack == eack, !ch ? "R5" : (wrl ? "R2" : "R3"), {7'd0, ack}, {7'd0, eack});
    chk(vld == evld, !ch ? "R5" : "R4", {7'd0, vld}, {7'd0, evld});
    chk(rdd == (evld ? ev : 8'h00), evld ? "R4" : "R6", rdd, evld ? ev : 8'h00);
    chk(ov == ev, out_tag(acc), ov, ev);
  endtask

  task automatic step(logic [7:0] a, bit w, bit r, logic [7:0] wd, logic [7:0] bi);
    bit ch;
    @(negedge clk);
    bus_addr = a; wr_en = w; rd_en = r; wr_data = wd; blk_in = bi;
    #1;
    ch = (a == ADDR);
    chk_inst(2, e_rw,  ch, hit_rw,  ack_rw,  vld_rw,  rdd_rw,  out_rw);
    chk_inst(1, e_wo,  ch, hit_wo,  ack_wo,  vld_wo,  rdd_wo,  out_wo);
    chk_inst(0, e_ro,  ch, hit_ro,  ack_ro,  vld_ro,  rdd_ro,  out_ro);
    chk_inst(3, e_cor, ch, hit_cor, ack_cor, vld_cor, rdd_cor, out_cor);
    chk_inst(4, e_cst, ch, hit_cst, ack_cst, vld_cst, rdd_cst, out_cst);
    e_rw  = nxt(2, e_rw,  ch, w, r, wd, bi);
    e_wo  = nxt(1, e_wo,  ch, w, r, wd, bi);
    e_ro  = nxt(0, e_ro,  ch, w, r, wd, bi);
    e_cor = nxt(3, e_cor, ch, w, r, wd, bi);
    e_cst = nxt(4, e_cst, ch, w, r, wd, bi);
  endtask

  // R10: values at INIT_VAL and both strobes low while reset holds.
  task automatic chk_reset_state();
    chk(out_rw == I_RW,   "R10", out_rw,  I_RW);
    chk(out_wo == I_WO,   "R10", out_wo,  I_WO);
    chk(out_ro == I_RO,   "R10", out_ro,  I_RO);
    chk(out_cor == I_COR, "R10", out_cor, I_COR);
    chk(out_cst == I_CST, "R10", out_cst, I_CST);
    chk(ack_rw == 1'b0,   "R10", {7'd0, ack_rw},  8'h00);
    chk(vld_cor == 1'b0,  "R10", {7'd0, vld_cor}, 8'h00);
  endtask

  task automatic release_reset();
    @(negedge clk);
    bus_addr = ADDR; wr_en = 1'b1; rd_en = 1'b1; wr_data = 8'hFF; blk_in = 8'h00;
    rst_n = 1'b1;
    // R10: during the two synchronising edges no access is legal.
    @(posedge clk); #1;
    chk(ack_rw == 1'b0, "R10", {7'd0, ack_rw}, 8'h00);
    chk(out_rw == I_RW, "R10", out_rw, I_RW);
    @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;
    repeat (2) @(posedge clk);
    e_rw = I_RW; e_wo = I_WO; e_ro = 8'h00; e_cor = 8'h00; e_cst = I_CST;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd4711));
    bus_addr = ADDR; wr_en = 1'b1; rd_en = 1'b0; wr_data = 8'h77; blk_in = 8'hF0;
    repeat (3) @(posedge clk);
    #1 chk_reset_state();
    release_reset();

    // R2: back-to-back writes 7 then 8, block input held high.
    step(ADDR, 1, 0, 8'h07, 8'hFF);
    step(ADDR, 1, 0, 8'h08, 8'hFF);
    step(ADDR, 0, 1, 8'h00, 8'h00);
    // R5: mismatched address read and write.
    step(8'h0F, 1, 1, 8'h99, 8'h00);
    // R8: event captured, kept after drop, cleared by read, new bit survives.
    step(8'h00, 0, 0, 8'h00, 8'h10);
    step(8'h00, 0, 0, 8'h00, 8'h00);
    step(ADDR, 0, 1, 8'h00, 8'h01);
    step(ADDR, 0, 1, 8'h00, 8'h00);
    step(ADDR, 0, 0, 8'h00, 8'h00);
    // R3/R9: writes to refusing types.
    step(ADDR, 1, 1, 8'hC3, 8'h42);
    step(ADDR, 0, 0, 8'h00, 8'h00);

    for (int i = 0; i < 600; i++) begin
      logic [7:0] a = ($urandom % 2) ? ADDR : 8'($urandom);
      step(a, ($urandom % 2) == 1, ($urandom % 4) == 0, 8'($urandom), 8'($urandom % 256) & 8'($urandom));
    end

    // R10: asynchronous reset mid-run, both polarities.
    @(negedge clk);
    bus_addr = ADDR; wr_en = 1'b1; rd_en = 1'b1; wr_data = 8'h00; blk_in = 8'hFF;
    rst_n = 1'b0;
    #1 chk_reset_state();
    release_reset();
    for (int i = 0; i < 100; i++) begin
      step(ADDR, ($urandom % 2) == 1, ($urandom % 3) == 0, 8'($urandom), 8'($urandom));
    end
    done = 1'b1;
    finish_run();
  end
endmodule